// File: doc/BRIEF.md
# I2C Controller Interrupt Status Logic

This block gathers condition signals from an I2C bus controller core into seven interrupt flags and combines them into one interrupt line. Some sources are single-cycle event pulses: transfer done, selected as slave, and not selected as slave. The others are levels derived each cycle: transmit throttle, bus idle, receive occupancy reaching its threshold, and transmit occupancy in its lower half. A flag driven by a level source stays forced to one while its condition holds. Firmware can only clear such a flag once the condition has gone.

Firmware reaches two 8-bit registers through a simple write/read port. The status register is cleared by toggling: each 1 written flips that flag, and each 0 leaves it alone. The enable register is loaded directly. Its bit 7 is a global enable and bits 6:0 mask the matching flags. The interrupt output is a pure function of the two registers.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every status flag, the enable register and `irq`. Flags whose source is active become set on the first clock after reset is released.
- R2: A status write (`reg_sel`=0, `reg_wr_en`=1) inverts each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged, provided that flag's source is inactive in that cycle.
- R3: Flag bit 1 (transmit empty) is set one cycle after `tx_throttle` is high. It stays set while `tx_throttle` is high, even if a toggle is written. A toggle clears it only once `tx_throttle` is low.
- R4: Flag bit 2 (receive full) is set while `rx_occ` equals `rx_thresh`. It cannot be cleared until the two values differ.
- R5: Flag bit 3 (bus idle) is set while `bus_busy` is low. It cannot be cleared while the bus stays idle.
- R6: Flag bit 6 (transmit half empty) is set while the most significant bit of `tx_occ` is 0.
- R7: The pulses `xfer_done_evt`, `slv_sel_evt` and `slv_unsel_evt` set flag bits 0, 4 and 5 respectively on the next clock. If a pulse and a toggle hit the same bit in the same cycle, the bit ends up set.
- R8: Every flag responds to its source with the same one-cycle latency. A transfer-done pulse that precedes bus release therefore sets bit 0 strictly before bit 3.
- R9: An enable write (`reg_sel`=1, `reg_wr_en`=1) loads all 8 bits of `reg_wdata` into the enable register. Bit 7 is the global enable and bits 6:0 are per-flag enables.
- R10: `irq` is 1 exactly when enable bit 7 is 1 and at least one flag is set whose per-flag enable bit is also 1.
- R11: `reg_rdata` returns the status flags with bit 7 reading 0 when `reg_sel`=0, and returns the enable register when `reg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_done_evt | input | 1 | Transfer-complete pulse |
| slv_sel_evt | input | 1 | Selected-as-slave pulse |
| slv_unsel_evt | input | 1 | Start followed by a non-matching address, pulse |
| tx_throttle | input | 1 | Transmit throttle level |
| bus_busy | input | 1 | Bus busy level |
| tx_occ | input | OCC_W | Transmit FIFO occupancy |
| rx_occ | input | OCC_W | Receive FIFO occupancy |
| rx_thresh | input | OCC_W | Programmable receive threshold |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes toggles while each level source is still active. A design that let a toggle win there would lose the transmit-empty, receive-full or bus-idle flag while its cause persists. It also lands an event pulse and a toggle on the same bit in the same cycle; a design with the wrong priority would read that bit back as cleared. Writes that flip a clear flag to set show whether a write of one really toggles or only clears. A transfer-done pulse followed one cycle later by bus release exposes a design whose flags have unequal latency.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NFLAG  = 7;
    localparam int DATA_W = 8;
    localparam int GLOBAL_EN_BIT = DATA_W - 1;

    typedef enum int {
        FL_XFER_DONE = 0,
        FL_TX_EMPTY  = 1,
        FL_RX_FULL   = 2,
        FL_BUS_IDLE  = 3,
        FL_SLV_SEL   = 4,
        FL_SLV_UNSEL = 5,
        FL_TX_HALF   = 6
    } flag_idx_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic xfer_done;
        logic slv_sel;
        logic slv_unsel;
        logic tx_throttle;
        logic bus_busy;
    } core_cond_t;

    function automatic logic irq_pending(input logic [NFLAG-1:0] flags,
                                         input logic [NFLAG-1:0] mask,
                                         input logic             global_en);
        return global_en & (|(flags & mask));
    endfunction

endpackage

// File: rtl/i2c_irq_src.sv
module i2c_irq_src
    import i2c_irq_pkg::*;
#(
    parameter int OCC_W = 4
) (
    input  core_cond_t        cond,
    input  logic [OCC_W-1:0]  tx_occ,
    input  logic [OCC_W-1:0]  rx_occ,
    input  logic [OCC_W-1:0]  rx_thresh,
    output logic [NFLAG-1:0]  src
);

    localparam int OCC_MSB = OCC_W - 1;

    always_comb begin
        src = '0;
        src[FL_XFER_DONE] = cond.xfer_done;
        src[FL_TX_EMPTY]  = cond.tx_throttle;
        src[FL_RX_FULL]   = (rx_occ == rx_thresh);
        src[FL_BUS_IDLE]  = ~cond.bus_busy;
        src[FL_SLV_SEL]   = cond.slv_sel;
        src[FL_SLV_UNSEL] = cond.slv_unsel;
        src[FL_TX_HALF]   = ~tx_occ[OCC_MSB];
    end

endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic tgl,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (src)
            q <= 1'b1;
        else if (tgl)
            q <= ~q;
    end

    // R7
    src_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        src |=> q);

    // R2
    toggle_flips_chk: assert property (@(posedge clk) disable iff (rst)
        (!src && tgl) |=> (q != $past(q)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!src && !tgl) |=> $stable(q));

endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NFLAG-1:0]  flags,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [DATA_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en && sel == SEL_ENABLE)
            en_q <= wdata;
    end

    always_comb begin
        if (sel == SEL_ENABLE)
            rdata = en_q;
        else
            rdata = {{(DATA_W-NFLAG){1'b0}}, flags};
    end

    assign irq = irq_pending(flags, en_q[NFLAG-1:0], en_q[GLOBAL_EN_BIT]);

    // R9
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ENABLE) |=> (en_q == $past(wdata)));

    // R10
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q[GLOBAL_EN_BIT] |-> !irq);

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_done_evt,
    input  logic             slv_sel_evt,
    input  logic             slv_unsel_evt,
    input  logic             tx_throttle,
    input  logic             bus_busy,
    input  logic [OCC_W-1:0] tx_occ,
    input  logic [OCC_W-1:0] rx_occ,
    input  logic [OCC_W-1:0] rx_thresh,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq
);

    core_cond_t       cond;
    reg_sel_e         sel;
    logic [NFLAG-1:0] src;
    logic [NFLAG-1:0] tgl;
    logic [NFLAG-1:0] flags;

    assign cond = '{xfer_done:   xfer_done_evt,
                    slv_sel:     slv_sel_evt,
                    slv_unsel:   slv_unsel_evt,
                    tx_throttle: tx_throttle,
                    bus_busy:    bus_busy};
    assign sel  = reg_sel_e'(reg_sel);
    assign tgl  = (reg_wr_en && sel == SEL_STATUS) ? reg_wdata[NFLAG-1:0] : '0;

    i2c_irq_src #(.OCC_W(OCC_W)) u_src (
        .cond      (cond),
        .tx_occ    (tx_occ),
        .rx_occ    (rx_occ),
        .rx_thresh (rx_thresh),
        .src       (src)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        i2c_irq_flag u_flag (
            .clk (clk),
            .rst (rst),
            .src (src[i]),
            .tgl (tgl[i]),
            .q   (flags[i])
        );
    end

    i2c_irq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .sel   (sel),
        .wdata (reg_wdata),
        .flags (flags),
        .rdata (reg_rdata),
        .irq   (irq)
    );

    // R3
    throttle_forces_chk: assert property (@(posedge clk) disable iff (rst)
        tx_throttle |=> flags[FL_TX_EMPTY]);

    // R5
    idle_forces_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |=> flags[FL_BUS_IDLE]);

    // R4
    rx_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_occ == rx_thresh) |=> flags[FL_RX_FULL]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == '0 && !irq));

endmodule

// File: tb/test_i2c_irq_ctrl.sv
module test_i2c_irq_ctrl;

    localparam int OCC_W = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             xfer_done_evt, slv_sel_evt, slv_unsel_evt;
    logic             tx_throttle, bus_busy;
    logic [OCC_W-1:0] tx_occ, rx_occ, rx_thresh;
    logic             reg_wr_en, reg_sel;
    logic [7:0]       reg_wdata;
    logic [7:0]       reg_rdata;
    logic             irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [6:0] m_st;
    logic [7:0] m_en;

    always #10 clk = ~clk;

    i2c_irq_ctrl #(.OCC_W(OCC_W)) i_i2c_irq_ctrl (
        .clk, .rst, .xfer_done_evt, .slv_sel_evt, .slv_unsel_evt,
        .tx_throttle, .bus_busy, .tx_occ, .rx_occ, .rx_thresh,
        .reg_wr_en, .reg_sel, .reg_wdata, .reg_rdata, .irq
    );

    function automatic logic [6:0] model_src();
        logic [6:0] s;
        s    = '0;
        s[0] = xfer_done_evt;
        s[1] = tx_throttle;
        s[2] = (rx_occ == rx_thresh);
        s[3] = ~bus_busy;
        s[4] = slv_sel_evt;
        s[5] = slv_unsel_evt;
        s[6] = ~tx_occ[OCC_W-1];
        return s;
    endfunction

    function automatic logic model_irq(input logic [6:0] st, input logic [7:0] en);
        return en[7] & (|(st & en[6:0]));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag);
        logic [6:0] s, t;
        logic       wen, wsel;
        logic [7:0] wd;
        s    = model_src();
        wen  = reg_wr_en;
        wsel = reg_sel;
        wd   = reg_wdata;
        t    = (wen && !wsel) ? wd[6:0] : 7'h0;
        @(posedge clk);
        if (rst) begin
            m_st = '0;
            m_en = '0;
        end else begin
            m_st = s | (m_st ^ t);
            if (wen && wsel) m_en = wd;
        end
        #5;
        check({tag, " R11 rdata"}, reg_rdata, reg_sel ? m_en : {1'b0, m_st});
        check({tag, " R10 irq"}, {7'h0, irq}, {7'h0, model_irq(m_st, m_en)});
        xfer_done_evt = 1'b0;
        slv_sel_evt   = 1'b0;
        slv_unsel_evt = 1'b0;
        reg_wr_en     = 1'b0;
    endtask

    task automatic quiet();
        tx_throttle = 1'b0;
        bus_busy    = 1'b1;
        tx_occ      = 4'h8;
        rx_occ      = 4'h1;
        rx_thresh   = 4'h5;
        reg_sel     = 1'b0;
    endtask

    task automatic tog(input logic [7:0] bits);
        reg_wr_en = 1'b1;
        reg_sel   = 1'b0;
        reg_wdata = bits;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0FFEE));
        m_st = '0; m_en = '0;
        rst = 1'b1;
        xfer_done_evt = 0; slv_sel_evt = 0; slv_unsel_evt = 0;
        reg_wr_en = 0; reg_wdata = '0;
        quiet();
        bus_busy = 1'b0;
        #5;
        apply("R1 reset");
        check("R1 status in reset", reg_rdata, 8'h00);
        reg_sel = 1'b1;
        apply("R1 reset");
        check("R1 enable in reset", reg_rdata, 8'h00);
        reg_sel = 1'b0;
        rst = 1'b0;
        apply("R1 release");
        check("R1 idle flag after release", reg_rdata, 8'h08);
        quiet();
        tog(8'h08);
        apply("R5 clear");
        check("R5 cleared once busy", reg_rdata, 8'h00);

        // R2: toggle sets, then clears; zero bits leave others alone
        tog(8'h11);
        apply("R2 set");
        check("R2 toggle to one", reg_rdata, 8'h11);
        tog(8'h01);
        apply("R2 clr");
        check("R2 toggle partial", reg_rdata, 8'h10);
        tog(8'h10);
        apply("R2 clr2");

        // R3
        tx_throttle = 1'b1;
        apply("R3 set");
        check("R3 throttle sets", reg_rdata, 8'h02);
        tog(8'h02);
        apply("R3 hold");
        check("R3 toggle blocked", reg_rdata, 8'h02);
        tx_throttle = 1'b0;
        tog(8'h02);
        apply("R3 clr");
        check("R3 clear after throttle gone", reg_rdata, 8'h00);

        // R4
        rx_occ = 4'h5;
        apply("R4 set");
        check("R4 match sets", reg_rdata, 8'h04);
        tog(8'h04);
        apply("R4 hold");
        check("R4 toggle blocked", reg_rdata, 8'h04);
        rx_occ = 4'h4;
        tog(8'h04);
        apply("R4 clr");
        check("R4 clear after read", reg_rdata, 8'h00);

        // R5
        bus_busy = 1'b0;
        apply("R5 set");
        tog(8'h08);
        apply("R5 hold");
        check("R5 toggle blocked idle", reg_rdata, 8'h08);
        bus_busy = 1'b1;
        tog(8'h08);
        apply("R5 clr");

        // R6
        tx_occ = 4'h7;
        apply("R6 set");
        check("R6 msb zero sets", reg_rdata, 8'h40);
        tx_occ = 4'h8;
        tog(8'h40);
        apply("R6 clr");
        check("R6 clear msb one", reg_rdata, 8'h00);

        // R7: pulses, and pulse wins over same-cycle toggle
        slv_sel_evt = 1'b1; slv_unsel_evt = 1'b1;
        apply("R7 evt");
        check("R7 slave flags", reg_rdata, 8'h30);
        xfer_done_evt = 1'b1;
        tog(8'h01);
        apply("R7 race");
        check("R7 pulse beats toggle", reg_rdata, 8'h31);
        slv_sel_evt = 1'b1;
        tog(8'h31);
        apply("R7 race2");
        check("R7 pulse beats toggle 2", reg_rdata, 8'h10);
        tog(8'h10);
        apply("R7 clr");

        // R8
        xfer_done_evt = 1'b1;
        apply("R8 a");
        check("R8 done first", reg_rdata, 8'h01);
        bus_busy = 1'b0;
        apply("R8 b");
        check("R8 idle after", reg_rdata, 8'h09);
        bus_busy = 1'b1;
        tog(8'h09);
        apply("R8 clr");

        // R9 / R10
        reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h04;
        apply("R9 load");
        check("R9 enable readback", reg_rdata, 8'h04);
        rx_occ = 4'h5;
        apply("R10 nogate");
        check("R10 global off", {7'h0, irq}, 8'h00);
        reg_wr_en = 1'b1; reg_wdata = 8'h84;
        apply("R10 gate");
        check("R10 irq asserted", {7'h0, irq}, 8'h01);
        reg_wr_en = 1'b1; reg_wdata = 8'hFB;
        apply("R10 mask");
        check("R10 masked flag", {7'h0, irq}, 8'h00);
        rx_occ = 4'h4;
        reg_sel = 1'b0;
        tog(8'h04);
        apply("R10 clr");

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            rst           = ($urandom_range(0, 99) == 0);
            xfer_done_evt = ($urandom_range(0, 5) == 0);
            slv_sel_evt   = ($urandom_range(0, 7) == 0);
            slv_unsel_evt = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 7) == 0) tx_throttle = ~tx_throttle;
            if ($urandom_range(0, 5) == 0) bus_busy = ~bus_busy;
            tx_occ    = 4'($urandom_range(0, 15));
            rx_occ    = 4'($urandom_range(0, 3));
            rx_thresh = 4'($urandom_range(0, 3));
            reg_wr_en = ($urandom_range(0, 2) == 0);
            reg_sel   = 1'($urandom_range(0, 1));
            reg_wdata = 8'($urandom_range(0, 255));
            apply("R2 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule